// File: doc/BRIEF.md
# AES-128 Round Key Schedule Store

This block turns a 128-bit cipher key into the full set of eleven AES-128 round keys. It writes them into an internal word-organised store that an iterative round datapath reads by round number. The datapath does not need to regenerate keys, so it can walk the schedule upward for encryption or downward for decryption with no extra cost.

A one-cycle load strobe captures the key and a mode select. In encryption-key mode the store holds the plain schedule. In decryption-key mode, round keys 1 to 9 are stored after the inverse column-mixing transform, which is the form a table-driven equivalent inverse cipher expects. Keys 0 and 10 stay untransformed. The schedule is produced one 32-bit word per clock, and the transform is applied on the fly to each word before it is written. Both modes therefore finish in the same number of cycles. A ready flag marks when the whole schedule is valid.

Top module: `aes_key_store`

## Requirements
- R1: After reset, ready_o is 0 and rd_key_o is all zeros for every index, until the first load has completed.
- R2: A cycle with load_i high captures key_i and dec_mode_i. ready_o is 0 on the following cycle and returns to 1 exactly 40 clock edges after the load edge, in either mode.
- R3: In both modes, round key 0 equals the loaded key. The first 32-bit word of the schedule is key_i[127:96].
- R4: In encryption-key mode, round key r (1..10) is the standard AES-128 expansion. Word i = word i-4 XOR temp. temp is word i-1, except when i is a multiple of 4: then temp is the rotate-left-by-one-byte of word i-1, passed byte-wise through the S-box and XORed in its top byte with the round constant 01,02,04,08,10,20,40,80,1B,36.
- R5: In decryption-key mode, each 32-bit column of round keys 1 to 9 is stored as the inverse column mix of the encryption column. Byte [31:24] is row 0, and the coefficients are 0E,0B,0D,09, rotated per row.
- R6: In decryption-key mode, round keys 0 and 10 are stored unchanged.
- R7: For rd_idx_i of 11 to 15, rd_key_o is all zeros.
- R8: A load while a schedule is still being built restarts expansion. ready_o stays 0 until 40 edges after the latest load, and the stored keys then reflect the latest key and mode.
- R9: Without a load, key_i and dec_mode_i have no effect. Once ready_o is 1, it stays 1 and the stored keys do not change until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Key capture strobe, one cycle |
| key_i | input | 128 | Cipher key, first schedule word in [127:96] |
| dec_mode_i | input | 1 | 1: store keys for the equivalent inverse cipher |
| ready_o | output | 1 | Whole schedule is valid |
| rd_idx_i | input | 4 | Round index to read |
| rd_key_o | output | 128 | Round key at rd_idx_i, combinational |

## Verification
A fault in the word window, the round-constant register or the S-box corrupts the first round key it touches and every later one. It is visible on a read of that round as soon as ready_o rises. A wrong word counter shows as ready_o rising at the wrong edge, caught against a 40-edge count from the load. A fault in mode capture or in the transform window shows only in decryption-key mode. There, keys 1 to 9 fail the forward-mix check and keys 0 and 10 fail direct comparison. Stale or stray writes show as keys changing after ready_o, or as a restart that leaves earlier words behind.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned KEY_W  = 128;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // a^254 by an addition chain; maps 0 to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
    x2   = gf_mul(a, a);
    x3   = gf_mul(x2, a);
    x6   = gf_mul(x3, x3);
    x12  = gf_mul(x6, x6);
    x15  = gf_mul(x12, x3);
    x30  = gf_mul(x15, x15);
    x60  = gf_mul(x30, x30);
    x120 = gf_mul(x60, x60);
    x240 = gf_mul(x120, x120);
    x252 = gf_mul(x240, x12);
    return gf_mul(x252, x2);
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_ks_sub_word.sv
module aes_ks_sub_word
  import aes_ks_pkg::*;
(
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] w_o
);
  localparam int unsigned NBYTES = WORD_W / 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign w_o[8*g +: 8] = sbox(w_i[8*g +: 8]);
  end
endmodule

// File: rtl/aes_ks_inv_mix.sv
module aes_ks_inv_mix
  import aes_ks_pkg::*;
(
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] w_o
);
  localparam int unsigned NROWS = WORD_W / 8;

  logic [7:0] a [NROWS];

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign a[r] = w_i[WORD_W-1-8*r -: 8];
  end

  for (genvar r = 0; r < NROWS; r++) begin : g_out
    assign w_o[WORD_W-1-8*r -: 8] = gf_mul(8'h0e, a[r])
                                  ^ gf_mul(8'h0b, a[(r+1)%NROWS])
                                  ^ gf_mul(8'h0d, a[(r+2)%NROWS])
                                  ^ gf_mul(8'h09, a[(r+3)%NROWS]);
  end
endmodule

// File: rtl/aes_ks_expand.sv
module aes_ks_expand
  import aes_ks_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 44,
  localparam int unsigned WIDX_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              busy_o,
  output logic [WIDX_W-1:0] wr_idx_o,
  output logic [WORD_W-1:0] wr_word_o
);
  localparam int unsigned NK = KEY_W / WORD_W;

  // win[0] is word i-4, win[NK-1] is word i-1
  logic [NK-1:0][WORD_W-1:0] win;
  logic [WIDX_W-1:0]         widx;
  logic [7:0]                rcon;
  logic                      busy;
  logic [WORD_W-1:0]         rot_w, sub_w, new_w;
  logic                      key_col;

  assign rot_w   = {win[NK-1][WORD_W-9:0], win[NK-1][WORD_W-1 -: 8]};
  assign key_col = (widx[1:0] == 2'd0);

  aes_ks_sub_word u_sub (
    .w_i (rot_w),
    .w_o (sub_w)
  );

  assign new_w = win[0] ^ (key_col ? (sub_w ^ {rcon, 24'h000000}) : win[NK-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win  <= '0;
      widx <= '0;
      rcon <= 8'h01;
      busy <= 1'b0;
    end else if (load_i) begin
      for (int k = 0; k < NK; k++) win[k] <= key_i[KEY_W-1-WORD_W*k -: WORD_W];
      widx <= WIDX_W'(NK);
      rcon <= 8'h01;
      busy <= 1'b1;
    end else if (busy) begin
      for (int k = 0; k < NK-1; k++) win[k] <= win[k+1];
      win[NK-1] <= new_w;
      widx      <= widx + 1'b1;
      if (key_col) rcon <= xtime(rcon);
      if (widx == WIDX_W'(NUM_WORDS-1)) busy <= 1'b0;
    end
  end

  assign busy_o    = busy;
  assign wr_idx_o  = widx;
  assign wr_word_o = new_w;
endmodule

// File: rtl/aes_ks_bank.sv
module aes_ks_bank
  import aes_ks_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 10,
  localparam int unsigned NUM_WORDS = 4*(NUM_ROUNDS+1),
  localparam int unsigned WIDX_W    = $clog2(NUM_WORDS),
  localparam int unsigned RIDX_W    = $clog2(NUM_ROUNDS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output logic [KEY_W-1:0]  rd_key_o
);
  localparam int unsigned NK = KEY_W / WORD_W;

  logic [WORD_W-1:0] mem [NUM_WORDS];
  logic [WIDX_W-1:0] base;
  logic              in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_WORDS; k++) mem[k] <= '0;
    end else if (ld_i) begin
      for (int k = 0; k < NK; k++) mem[k] <= key_i[KEY_W-1-WORD_W*k -: WORD_W];
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= wr_word_i;
    end
  end

  assign base     = WIDX_W'({rd_idx_i, 2'b00});
  assign in_range = (rd_idx_i <= RIDX_W'(NUM_ROUNDS));

  for (genvar c = 0; c < NK; c++) begin : g_col
    assign rd_key_o[KEY_W-1-WORD_W*c -: WORD_W] =
      in_range ? mem[base + WIDX_W'(c)] : '0;
  end
endmodule

// File: rtl/aes_key_store.sv
module aes_key_store
  import aes_ks_pkg::*;
#(
  parameter int unsigned NUM_ROUNDS = 10,
  localparam int unsigned RIDX_W    = $clog2(NUM_ROUNDS+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [127:0]      key_i,
  input  logic              dec_mode_i,
  output logic              ready_o,
  input  logic [RIDX_W-1:0] rd_idx_i,
  output logic [127:0]      rd_key_o
);
  localparam int unsigned NUM_WORDS = 4*(NUM_ROUNDS+1);
  localparam int unsigned WIDX_W    = $clog2(NUM_WORDS);
  localparam int unsigned NK        = KEY_W / WORD_W;

  logic              busy;
  logic [WIDX_W-1:0] wr_idx;
  logic [WORD_W-1:0] exp_word, imc_word, st_word;
  logic              dec_q, loaded_q, mid_round;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (load_i) begin
      dec_q    <= dec_mode_i;
      loaded_q <= 1'b1;
    end
  end

  aes_ks_expand #(.NUM_WORDS(NUM_WORDS)) u_expand (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .key_i     (key_i),
    .busy_o    (busy),
    .wr_idx_o  (wr_idx),
    .wr_word_o (exp_word)
  );

  aes_ks_inv_mix u_imc (
    .w_i (exp_word),
    .w_o (imc_word)
  );

  // first and last round keys bypass the transform
  assign mid_round = (wr_idx >= WIDX_W'(NK)) && (wr_idx < WIDX_W'(NUM_WORDS-NK));
  assign st_word   = (dec_q && mid_round) ? imc_word : exp_word;

  aes_ks_bank #(.NUM_ROUNDS(NUM_ROUNDS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (load_i),
    .key_i     (key_i),
    .wr_en_i   (busy),
    .wr_idx_i  (wr_idx),
    .wr_word_i (st_word),
    .rd_idx_i  (rd_idx_i),
    .rd_key_o  (rd_key_o)
  );

  assign ready_o = loaded_q & ~busy;
endmodule

// File: rtl/aes_key_store_chk.sv
module aes_key_store_chk #(
  parameter int unsigned NUM_ROUNDS = 10,
  localparam int unsigned RIDX_W    = $clog2(NUM_ROUNDS+1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [127:0]      key_i,
  input logic              ready_o,
  input logic [RIDX_W-1:0] rd_idx_i,
  input logic [127:0]      rd_key_o
);
  localparam logic [15:0] LAT = 16'(4*NUM_ROUNDS + 1);

  logic [15:0]  cnt;
  logic         seen_q;
  logic [127:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= '0;
      seen_q <= 1'b0;
      key_q  <= '0;
    end else if (load_i) begin
      cnt    <= 16'd1;
      seen_q <= 1'b1;
      key_q  <= key_i;
    end else if (cnt != 16'd0 && cnt != 16'hffff) begin
      cnt <= cnt + 16'd1;
    end
  end

  a_r1_ready_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> seen_q);

  a_r2_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ready_o);

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> cnt == LAT);

  a_r3_key0_is_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_idx_i == '0) |-> rd_key_o == key_q);

  a_r7_high_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i > RIDX_W'(NUM_ROUNDS)) |-> rd_key_o == '0);

  a_r9_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !load_i) |=> ready_o);
endmodule

bind aes_key_store aes_key_store_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_i   (load_i),
  .key_i    (key_i),
  .ready_o  (ready_o),
  .rd_idx_i (rd_idx_i),
  .rd_key_o (rd_key_o)
);

// File: tb/tb_aes_key_store.sv
module tb_aes_key_store;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [127:0] key = '0;
  logic         dec_mode = 1'b0;
  logic         ready;
  logic [3:0]   rd_idx = '0;
  logic [127:0] rd_key;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_w [44];

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_key_store dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .key_i      (key),
    .dec_mode_i (dec_mode),
    .ready_o    (ready),
    .rd_idx_i   (rd_idx),
    .rd_key_o   (rd_key)
  );

  // ---- bench reference model ----
  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    for (int i = 7; i >= 0; i--) acc = m_xt(acc) ^ (a[i] ? b : 8'h00);
    return acc;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
    return s ^ 8'h63;
  endfunction

  function automatic logic [31:0] m_fwd_mix(input logic [31:0] w);
    logic [7:0] a [4];
    logic [31:0] o;
    for (int r = 0; r < 4; r++) a[r] = w[31-8*r -: 8];
    for (int r = 0; r < 4; r++)
      o[31-8*r -: 8] = m_mul(8'h02, a[r]) ^ m_mul(8'h03, a[(r+1)%4]) ^ a[(r+2)%4] ^ a[(r+3)%4];
    return o;
  endfunction

  task automatic m_expand(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < 4; i++) exp_w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = exp_w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
        t = t ^ {rc, 24'h0};
        rc = m_xt(rc);
      end
      exp_w[i] = exp_w[i-4] ^ t;
    end
  endtask

  // ---- check helpers ----
  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [127:0] v);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1;
    v = rd_key;
  endtask

  task automatic do_load(input logic [127:0] k, input logic m);
    @(negedge clk);
    load = 1'b1; key = k; dec_mode = m;
    @(negedge clk);
    load = 1'b0;
    chk("R2 ready low after load", 128'(ready), 128'd0);
    repeat (39) @(negedge clk);
    chk("R2 ready still low at edge 39", 128'(ready), 128'd0);
    @(negedge clk);
    chk("R2 ready high at edge 40", 128'(ready), 128'd1);
  endtask

  task automatic check_all(input logic [127:0] k, input logic m);
    logic [127:0] v, e;
    logic [31:0] mixed;
    m_expand(k);
    for (int r = 0; r <= 10; r++) begin
      rd(r, v);
      e = {exp_w[4*r], exp_w[4*r+1], exp_w[4*r+2], exp_w[4*r+3]};
      if (r == 0) chk("R3 round key 0", v, e);
      else if (!m) chk("R4 enc round key", v, e);
      else if (r == 10) chk("R6 dec last key untouched", v, e);
      else begin
        for (int c = 0; c < 4; c++) begin
          mixed = m_fwd_mix(v[127-32*c -: 32]);
          v[127-32*c -: 32] = mixed;
        end
        chk("R5 dec key forward-mixed", v, e);
      end
    end
    for (int r = 11; r < 16; r++) begin
      rd(r, v);
      chk("R7 high index zero", v, 128'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    logic [127:0] lk;
    logic [127:0] fips_k;
    fips_k = 128'h2b7e151628aed2a6abf7158809cf4f3c;

    repeat (3) @(negedge clk);
    chk("R1 ready low after reset", 128'(ready), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready low before load", 128'(ready), 128'd0);
    for (int r = 0; r < 16; r++) begin
      rd(r, v);
      chk("R1 empty store reads zero", v, 128'd0);
    end

    // known vector, encryption
    do_load(fips_k, 1'b0);
    rd(1, v);
    chk("R4 known round 1", v, 128'ha0fafe1788542cb123a339392a6c7605);
    rd(5, v);
    chk("R4 known round 5", v, 128'hd4d1c6f87c839d87caf2b8bc11f915bc);
    rd(10, v);
    chk("R4 known round 10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    check_all(fips_k, 1'b0);

    // known vector, decryption
    do_load(fips_k, 1'b1);
    rd(10, v);
    chk("R6 dec known round 10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    check_all(fips_k, 1'b1);

    // sweep of keys in both modes
    lk = 128'h0;
    for (int n = 0; n < 6; n++) begin
      for (int m = 0; m < 2; m++) begin
        do_load(lk, m[0]);
        check_all(lk, m[0]);
      end
      lk = {lk[95:0], lk[127:96]} * 128'd6364136223846793005 + 128'h1442695040888963407f4a7c15ffffff;
      if (n == 3) lk = '1;
    end

    // R8 restart mid-expansion
    @(negedge clk);
    load = 1'b1; key = 128'h00112233445566778899aabbccddeeff; dec_mode = 1'b0;
    @(negedge clk);
    load = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 still busy mid-expansion", 128'(ready), 128'd0);
    do_load(128'h000102030405060708090a0b0c0d0e0f, 1'b1);
    check_all(128'h000102030405060708090a0b0c0d0e0f, 1'b1);

    // R9 inputs ignored without load
    @(negedge clk);
    key = 128'hdeadbeefdeadbeefdeadbeefdeadbeef; dec_mode = 1'b0;
    repeat (50) @(negedge clk);
    chk("R9 ready holds without load", 128'(ready), 128'd1);
    check_all(128'h000102030405060708090a0b0c0d0e0f, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule